// File: doc/BRIEF.md
# Cascaded 54x54 Mantissa Multiplier

This block multiplies two unsigned 54-bit operands and returns the full 108-bit product. It is meant for the mantissa datapath of a double-precision multiply unit: a 53-bit significand, hidden bit included at bit 52, sits in the low bits of each operand and the top operand bit may stay zero. Exponents, rounding and normalisation belong to neighbouring logic.

The product is not formed by one wide multiplier. Each operand is cut into a low and a high 27-bit half, and four registered 27x27 stages each add one partial product to a running sum that travels along a 64-bit cascade. The order is low-by-low (weight 0), low-A by high-B (weight 27), high-A by low-B (weight 27), high-by-high (weight 54). After the first and third stages the low 27 bits of the running sum are final product bits. They are peeled off and delayed to the output, and the rest moves on shifted right by 27. Operand halves ride a delay line beside the chain, so one operand pair can enter on every cycle. A per-transfer narrow flag selects a single-precision style product that uses only the low-by-low stage.

Both edges are valid/ready streams. A transfer happens on a rising edge where valid and ready are both high. The whole pipeline stalls as one unit. It moves when the output holds nothing or the sink is ready, and `in_ready` reflects exactly that condition. While the sink holds off, a presented result stays frozen and the source is held off too.

Top module: `mm54_cascade_mul`

## Requirements
- R1: For every pair of 54-bit unsigned operands with the narrow flag low, `out_prod` equals the exact 108-bit unsigned product `in_a * in_b`.
- R2: Carries that cross the 27-bit half boundaries are kept, including operands whose halves are all ones or all zeros.
- R3: A 53-bit mantissa with its hidden bit at bit 52 (bit 53 zero) multiplies exactly; 2^52 times 2^52 gives a single one at product bit 104.
- R4: With `in_narrow` high, `out_prod` equals `in_a[26:0] * in_b[26:0]`; operand bits 53..27 have no effect and product bits 107..54 are zero.
- R5: With `out_ready` held high, a result appears on `out_valid` after the fourth rising edge, counting the edge that accepts the operands.
- R6: While `out_ready` stays high, `in_ready` stays high, and one operand pair is accepted on every cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_prod` hold their values on the next cycle and `in_ready` is low.
- R8: During and right after reset, `out_valid` is low and `in_ready` is high.
- R9: Results leave in acceptance order, with none lost or duplicated, under any pattern of input gaps and output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block accepts an operand pair this cycle |
| in_a | input | 54 | Multiplicand |
| in_b | input | 54 | Multiplier |
| in_narrow | input | 1 | Use only the low 27 bits of each operand |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Sink accepts the product this cycle |
| out_prod | output | 108 | Unsigned product |

## Verification
The delicate overlap is a stall landing while a new operand pair is offered and an earlier result waits at the output. The frozen pipeline must neither drop the offered pair nor change the held product. The bench provokes this with random `in_valid` and `out_ready` patterns over thousands of cycles, mixing narrow and full transfers. It judges each transfer against a queue of reference products computed in the bench at the moment of acceptance, and it also checks that every held product stays unchanged on the cycle after a refused handshake.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // split width of one partial-product unit
  localparam int HALF_W = 27;
  // width of the running-sum path between units
  localparam int CASC_W = 64;
  // number of chained units
  localparam int N_UNITS = 4;
endpackage

// File: rtl/mm_stage.sv
module mm_stage #(
  parameter int HW   = 27,
  parameter int CW   = 64,
  parameter int USED = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          gate,
  input  logic [HW-1:0] x,
  input  logic [HW-1:0] y,
  input  logic [CW-1:0] casc_in,
  output logic [CW-1:0] casc_q
);
  logic [2*HW-1:0] pp;
  logic [CW-1:0]   sum;

  assign pp  = gate ? '0 : x * y;
  assign sum = casc_in + CW'(pp);

  always_ff @(posedge clk) begin
    if (!rst_n)  casc_q <= '0;
    else if (en) casc_q <= sum;
  end

  // R1
  casc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q[CW-1:USED] == '0);

  // R7
  stage_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(casc_q));
endmodule

// File: rtl/mm_delay.sv
module mm_delay #(
  parameter int W = 8,
  parameter int D = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [D*W-1:0] taps
);
  logic [W-1:0] r [D];

  for (genvar i = 0; i < D; i++) begin : g_tap
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n)  r[i] <= '0;
        else if (en) r[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n)  r[i] <= '0;
        else if (en) r[i] <= r[i-1];
      end
    end
    assign taps[i*W +: W] = r[i];
  end
endmodule

// File: rtl/mm54_cascade_mul.sv
module mm54_cascade_mul
  import mm_pkg::*;
#(
  parameter int HALF = HALF_W,
  parameter int CASW = CASC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2*HALF-1:0]  in_a,
  input  logic [2*HALF-1:0]  in_b,
  input  logic               in_narrow,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [4*HALF-1:0]  out_prod
);
  localparam int OPW   = 2 * HALF;
  localparam int PRODW = 4 * HALF;
  localparam int NST   = N_UNITS;
  localparam int ND    = NST - 1;
  localparam int BW    = 1 + 2 * OPW;

  logic            advance;
  logic [NST-1:0]  vld;
  logic [NST-1:0]  nar;

  assign out_valid = vld[NST-1];
  assign advance   = !out_valid || out_ready;
  assign in_ready  = advance;

  // valid and narrow tags march with the data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      nar <= '0;
    end else if (advance) begin
      vld <= {vld[NST-2:0], in_valid};
      nar <= {nar[NST-2:0], in_narrow};
    end
  end

  // operand halves delayed to line up with each unit
  logic [ND*BW-1:0] taps;
  logic [OPW-1:0]   ta [ND];
  logic [OPW-1:0]   tb [ND];
  logic             tn [ND];

  mm_delay #(.W(BW), .D(ND)) u_ops (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (advance),
    .d    ({in_narrow, in_a, in_b}),
    .taps (taps)
  );

  for (genvar k = 0; k < ND; k++) begin : g_unpack
    assign tn[k] = taps[k*BW + BW - 1];
    assign ta[k] = taps[k*BW + OPW +: OPW];
    assign tb[k] = taps[k*BW +: OPW];
  end

  // per-unit operand routing: LL, LA*HB, HA*LB, HH
  logic [HALF-1:0] sx  [NST];
  logic [HALF-1:0] sy  [NST];
  logic            sg  [NST];
  logic [CASW-1:0] cin [NST];
  logic [CASW-1:0] cq  [NST];

  always_comb begin
    sx[0]  = in_a[HALF-1:0];
    sy[0]  = in_b[HALF-1:0];
    sg[0]  = 1'b0;
    cin[0] = '0;

    sx[1]  = ta[0][HALF-1:0];
    sy[1]  = tb[0][OPW-1:HALF];
    sg[1]  = tn[0];
    cin[1] = cq[0] >> HALF;

    sx[2]  = ta[1][OPW-1:HALF];
    sy[2]  = tb[1][HALF-1:0];
    sg[2]  = tn[1];
    cin[2] = cq[1];

    sx[3]  = ta[2][OPW-1:HALF];
    sy[3]  = tb[2][OPW-1:HALF];
    sg[3]  = tn[2];
    cin[3] = cq[2] >> HALF;
  end

  for (genvar s = 0; s < NST; s++) begin : g_unit
    mm_stage #(.HW(HALF), .CW(CASW), .USED(OPW + 2)) u_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (advance),
      .gate   (sg[s]),
      .x      (sx[s]),
      .y      (sy[s]),
      .casc_in(cin[s]),
      .casc_q (cq[s])
    );
  end

  // finished low product bits, delayed to the output
  logic [HALF-1:0] lo1, lo2, lo3, mid3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo1  <= '0;
      lo2  <= '0;
      lo3  <= '0;
      mid3 <= '0;
    end else if (advance) begin
      lo1  <= cq[0][HALF-1:0];
      lo2  <= lo1;
      lo3  <= lo2;
      mid3 <= cq[2][HALF-1:0];
    end
  end

  assign out_prod = {cq[NST-1][OPW-1:0], mid3, lo3};

  logic unused_bits;
  assign unused_bits = ^{cq[NST-1][CASW-1:OPW], tn[ND-1], ta[ND-1][HALF-1:0], tb[ND-1][HALF-1:0]};

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prod));

  // R4
  narrow_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && nar[NST-1] |-> out_prod[PRODW-1:OPW] == '0);
endmodule

// File: tb/sim_mm54_cascade_mul.sv
module sim_mm54_cascade_mul;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [53:0]  in_a = '0;
  logic [53:0]  in_b = '0;
  logic         in_narrow = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [107:0] out_prod;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [107:0] expq [$];
  string        tagq [$];
  bit           held = 0;
  logic [107:0] held_val;

  always #2 clk = ~clk;

  mm54_cascade_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_narrow(in_narrow),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  function automatic logic [107:0] ref_prod(logic [53:0] a, logic [53:0] b, logic n);
    logic [107:0] wa, wb;
    if (n) begin
      wa = {81'b0, a[26:0]};
      wb = {81'b0, b[26:0]};
    end else begin
      wa = {54'b0, a};
      wb = {54'b0, b};
    end
    return wa * wb;
  endfunction

  function automatic logic [53:0] rnd54();
    return {$urandom, $urandom} & {54{1'b1}};
  endfunction

  task automatic check(string req, logic [107:0] act, logic [107:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, then judge the handshakes of the coming edge
  task automatic step(logic v, logic [53:0] a, logic [53:0] b, logic n, logic rdy, string tag);
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_narrow = n; out_ready = rdy;
    #1;
    if (held) begin
      // R7: held output unchanged
      check("R7", {107'b0, out_valid}, 108'd1);
      check("R7", out_prod, held_val);
      held = 0;
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check("R9", 108'd1, 108'd0);
      end else begin
        check(tagq.pop_front(), out_prod, expq.pop_front());
      end
    end
    if (out_valid && !out_ready) begin
      check("R7", {107'b0, in_ready}, 108'd0);
      held = 1;
      held_val = out_prod;
    end
    if (in_valid && in_ready) begin
      expq.push_back(ref_prod(a, b, n));
      tagq.push_back(tag);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8", {107'b0, out_valid}, 108'd0);
    check("R8", {107'b0, in_ready}, 108'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", {107'b0, out_valid}, 108'd0);

    // directed corners
    step(1, 54'd0, rnd54(), 0, 1, "R1");
    step(1, 54'd1, 54'h2A_5A5A_5A5A_5A5A, 0, 1, "R1");
    step(1, {54{1'b1}}, {54{1'b1}}, 0, 1, "R2");
    step(1, {27'h7FFFFFF, 27'h0}, {27'h0, 27'h7FFFFFF}, 0, 1, "R2");
    step(1, {27'h0, 27'h7FFFFFF}, {27'h7FFFFFF, 27'h7FFFFFF}, 0, 1, "R2");
    step(1, 54'd1 << 52, 54'd1 << 52, 0, 1, "R3");
    step(1, {1'b0, {53{1'b1}}}, {1'b0, {53{1'b1}}}, 0, 1, "R3");
    step(1, {27'h5A5A5A5, 27'h7FFFFFF}, {27'h7FFFFFF, 27'h7FFFFFF}, 1, 1, "R4");
    step(1, {27'h7FFFFFF, 27'h0123456}, {27'h3C3C3C3, 27'h0ABCDEF}, 1, 1, "R4");
    for (int i = 0; i < 6; i++) step(0, '0, '0, 0, 1, "R1");

    // R5: latency
    begin
      int lat;
      step(1, 54'd12345, 54'd678, 0, 1, "R5");
      lat = 0;
      for (int i = 0; i < 8; i++) begin
        step(0, '0, '0, 0, 1, "R5");
        if (lat == 0 && out_valid) lat = i + 1;
      end
      check("R5", 108'(lat), 108'd4);
    end

    // R6: back-to-back
    begin
      int not_ready;
      not_ready = 0;
      for (int i = 0; i < 24; i++) begin
        step(1, rnd54(), rnd54(), (i % 3) == 0, 1, "R6");
        if (!in_ready) not_ready++;
      end
      check("R6", 108'(not_ready), 108'd0);
      for (int i = 0; i < 6; i++) step(0, '0, '0, 0, 1, "R6");
    end

    // R9: random traffic with stalls
    for (int i = 0; i < 3000; i++) begin
      logic [53:0] a, b;
      a = rnd54(); b = rnd54();
      if ($urandom % 16 == 0) a = {54{1'b1}};
      if ($urandom % 16 == 0) b = {1'b0, 1'b1, 52'b0};
      step(($urandom % 4) != 0, a, b, ($urandom % 5) == 0, ($urandom % 3) != 0, "R9");
    end
    for (int i = 0; i < 12; i++) step(0, '0, '0, 0, 1, "R9");
    check("R9", 108'(expq.size()), 108'd0);

    finish_run();
  end
endmodule